// File: doc/BRIEF.md
# Eight-Channel Word Collector with Shared FIFO

This block gathers finished data words from eight independent input channels into one shared queue. A single register sits in front of the queue for each channel. It holds a word that has arrived but has not yet been taken. Every cycle, a fixed-priority arbiter picks the lowest-numbered channel that holds a word and moves that word into the queue, provided there is room.

The host sees a small register window with a combinational read path. It has a data register that pops the queue head when read, a status register with the entry count and one sticky overflow flag per channel, and a control register. The control register holds a mode bit that decides whether reading an empty queue stalls the host or completes at once. It also holds a write-one bit that clears the overflow flags.

Top module: `chan_word_fifo`

## Requirements
- R1: After synchronous reset the queue is empty, the count reads 0, no channel holds a word, all overflow flags are 0 and the no-stall mode bit is 0.
- R2: A word presented with `ch_valid[i]` at clock edge t is stored in channel i's holding register. It is written into the queue at edge t+1 at the earliest.
- R3: When several holding registers are occupied, the queue accepts one word per cycle, taken from the lowest-numbered occupied channel.
- R4: Address 0 reads the queue head, zero-extended. A read of address 0 with `rd_req` high and a non-empty queue removes the head at the clock edge, and words leave in the order they entered.
- R5: Address 1 returns the entry count (0 to 8) in bits [3:0]. The count rises by one per accepted push and falls by one per pop.
- R6: Address 1 bits [8+i] hold channel i's overflow flag. The flag is set when a new word arrives on channel i while its previous word is still held and is not being moved into the queue in that cycle. The new word replaces the held one. A set flag stays set.
- R7: Writing address 2 with bit 1 = 1 clears all overflow flags. A flag being set in the same cycle stays set. Bit 1 of address 2 always reads 0.
- R8: Address 2 bit 0 is the no-stall mode bit and is written and read back there. While it is 0, a read of address 0 on an empty queue holds `rd_ready` low and removes nothing until a word is present.
- R9: While the no-stall bit is 1, a read of address 0 on an empty queue has `rd_ready` high, returns 0 and leaves the count unchanged.
- R10: When the queue holds 8 entries, a pop and a push in the same cycle are both accepted and the count stays 8.
- R11: While the queue is full and no pop occurs, held words stay in their channels and are not lost. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_valid | input | NCH | Per-channel word-complete strobe |
| ch_data | input | NCH*DW | Channel words, channel i at bits [i*DW +: DW] |
| rd_req | input | 1 | Host read strobe |
| rd_addr | input | 2 | Host read address |
| rd_data | output | BW | Read data (combinational) |
| rd_ready | output | 1 | Read completes this cycle when high |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | BW | Host write data |

## Verification
A wrong pointer or count appears at once in the next read of address 0 or address 1. It shows as a word out of order, a stale word, or a count off by one. A wrong arbitration or overflow decision shows as a word missing from the pop sequence, or as an unexpected flag bit in the status word, within the few cycles it takes to drain the queue. Because the bench reference model compares `rd_ready` and `rd_data` every cycle, a stall asserted or released one cycle early is caught in that same cycle.

// File: rtl/chan_word_fifo.sv
module chan_word_fifo #(
  parameter int NCH   = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int BW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ch_valid,
  input  logic [NCH*DW-1:0] ch_data,
  input  logic              rd_req,
  input  logic [1:0]        rd_addr,
  output logic [BW-1:0]     rd_data,
  output logic              rd_ready,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BW-1:0]     wr_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int GW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [DW-1:0]  pend_q [NCH];
  logic [NCH-1:0] pend_v, ovf_q;
  logic [DW-1:0]  mem [DEPTH];
  logic [PW-1:0]  wptr, rptr;
  logic [CW-1:0]  count_q;
  logic           hd_q;
  logic [GW-1:0]  gnt;
  logic           any;

  always_comb begin
    gnt = '0;
    any = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_v[i]) begin
        gnt = i[GW-1:0];
        any = 1'b1;
      end
    end
  end

  wire empty   = (count_q == '0);
  wire full    = (count_q == CW'(DEPTH));
  wire data_rd = rd_req && (rd_addr == 2'd0);
  wire pop     = data_rd && !empty;
  wire push    = any && (!full || pop);
  wire clr     = wr_en && (wr_addr == 2'd2) && wr_data[1];

  assign rd_ready = !(data_rd && empty && !hd_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= '0;
      ovf_q  <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_valid[i]) begin
          pend_v[i] <= 1'b1;
          pend_q[i] <= ch_data[i*DW +: DW];
        end else if (push && gnt == i[GW-1:0]) begin
          pend_v[i] <= 1'b0;
        end
        if (ch_valid[i] && pend_v[i] && !(push && gnt == i[GW-1:0]))
          ovf_q[i] <= 1'b1;
        else if (clr)
          ovf_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= pend_q[gnt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count_q <= '0;
      hd_q    <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count_q <= count_q + CW'(push) - CW'(pop);
      if (wr_en && wr_addr == 2'd2) hd_q <= wr_data[0];
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = empty ? '0 : BW'(mem[rptr]);
      2'd1:    rd_data = (BW'(ovf_q) << 8) | BW'(count_q);
      2'd2:    rd_data = BW'(hd_q);
      default: rd_data = '0;
    endcase
  end
endmodule

module chan_word_fifo_chk #(
  parameter int NCH   = 8,
  parameter int DEPTH = 8,
  parameter int CW    = 4,
  parameter int BW    = 32
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] ch_valid,
  input logic           rd_req,
  input logic [1:0]     rd_addr,
  input logic           rd_ready,
  input logic           wr_en,
  input logic [1:0]     wr_addr,
  input logic [BW-1:0]  wr_data,
  input logic [CW-1:0]  count_q,
  input logic [NCH-1:0] ovf_q,
  input logic [NCH-1:0] pend_v,
  input logic           hd_q
);
  wire clr_w  = wr_en && wr_addr == 2'd2 && wr_data[1];
  wire rd0    = rd_req && rd_addr == 2'd0;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (count_q == '0 && ovf_q == '0 && pend_v == '0 && !hd_q)); // R1
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst) count_q <= CW'(DEPTH)); // R5
  AST_POP_COUNT: assert property (@(posedge clk) disable iff (rst) (rd0 && count_q != '0 && pend_v == '0) |=> count_q == $past(count_q) - 1'b1); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) !clr_w |=> (ovf_q & $past(ovf_q)) == $past(ovf_q)); // R6
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst) (clr_w && ch_valid == '0) |=> ovf_q == '0); // R7
  AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (rst) (rd0 && count_q == '0 && !hd_q) |-> !rd_ready); // R8
  AST_NO_STALL: assert property (@(posedge clk) disable iff (rst) hd_q |-> rd_ready); // R9
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst) (rd0 && count_q == CW'(DEPTH) && pend_v != '0) |=> count_q == CW'(DEPTH)); // R10
endmodule

bind chan_word_fifo chan_word_fifo_chk #(.NCH(NCH), .DEPTH(DEPTH), .CW(CW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .ch_valid(ch_valid), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_ready(rd_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .count_q(count_q), .ovf_q(ovf_q), .pend_v(pend_v), .hd_q(hd_q)
);

// File: tb/chan_word_fifo_bench.sv
module chan_word_fifo_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ch_valid = '0;
  logic [15:0] chd [8];
  logic [127:0] ch_data;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_ready;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) ch_data[i*16 +: 16] = chd[i];

  chan_word_fifo u_chan_word_fifo (
    .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_data(ch_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int unsigned q[$];
  bit          m_pend [8];
  int unsigned m_pdat [8];
  bit [7:0]    m_ovf;
  bit          m_hd;
  int errors = 0;
  int checks = 0;

  task automatic model_reset();
    q.delete();
    for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_pdat[i] = 0; end
    m_ovf = '0;
    m_hd  = 0;
  endtask

  task automatic check(string tag);
    bit          e_rdy;
    int unsigned e_dat;
    e_rdy = !(rd_req && rd_addr == 0 && q.size() == 0 && !m_hd);
    case (rd_addr)
      2'd0: e_dat = (q.size() == 0) ? 0 : q[0];
      2'd1: e_dat = (int'(m_ovf) << 8) | q.size();
      2'd2: e_dat = m_hd;
      default: e_dat = 0;
    endcase
    checks++;
    if (rd_ready !== e_rdy) begin
      errors++;
      $display("FAIL %s rd_ready actual=%0b expected=%0b at %0t", tag, rd_ready, e_rdy, $time);
    end
    checks++;
    if (rd_data !== e_dat) begin
      errors++;
      $display("FAIL %s rd_data addr=%0d actual=%0h expected=%0h at %0t", tag, rd_addr, rd_data, e_dat, $time);
    end
  endtask

  task automatic model_step();
    int  g;
    bit  pop, push;
    g = -1;
    for (int i = 7; i >= 0; i--) if (m_pend[i]) g = i;
    pop  = rd_req && rd_addr == 0 && q.size() > 0;
    push = (g >= 0) && (q.size() < 8 || pop);
    if (pop)  void'(q.pop_front());
    if (push) q.push_back(m_pdat[g]);
    if (wr_en && wr_addr == 2 && wr_data[1]) m_ovf = '0;
    if (wr_en && wr_addr == 2) m_hd = wr_data[0];
    for (int i = 0; i < 8; i++) begin
      if (ch_valid[i]) begin
        if (m_pend[i] && !(push && g == i)) m_ovf[i] = 1;
        m_pend[i] = 1;
        m_pdat[i] = chd[i];
      end else if (push && g == i) begin
        m_pend[i] = 0;
      end
    end
  endtask

  task automatic cyc(string tag);
    @(negedge clk);
    if (!rst) check(tag);
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    #1;
    ch_valid = '0;
    wr_en    = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) cyc(tag);
  endtask

  task automatic send(int ch, int unsigned v);
    ch_valid[ch] = 1'b1;
    chd[ch] = v[15:0];
  endtask

  task automatic rd(bit on, logic [1:0] a);
    rd_req  = on;
    rd_addr = a;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) chd[i] = '0;
    model_reset();
    idle(3, "R1 reset");
    rst = 1'b0;
    #1;
    rd(0, 2'd1); idle(2, "R1 status after reset");
    rd(0, 2'd2); idle(1, "R1 control after reset");
    rd(0, 2'd3); idle(1, "R11 unused address");

    // single word
    send(4, 16'hA504); idle(3, "R2 single word");
    rd(1, 2'd0); idle(1, "R4 pop single");
    rd(0, 2'd1); idle(1, "R5 count back to 0");

    // all channels at once: priority order
    for (int i = 0; i < 8; i++) send(i, 16'h1000 + i);
    rd(0, 2'd1); idle(10, "R3 priority fill");
    for (int i = 0; i < 8; i++) begin rd(1, 2'd0); idle(1, "R3 R4 pop order"); end
    rd(0, 2'd1); idle(1, "R5 empty count");

    // mixed pattern
    send(6, 16'h6666); send(1, 16'h1111); idle(1, "R3 mixed");
    send(3, 16'h3333); idle(1, "R3 mixed late");
    idle(3, "R2 mixed settle");
    for (int i = 0; i < 3; i++) begin rd(1, 2'd0); idle(1, "R4 mixed pop"); end

    // fill, then hold words pending, then overflow
    for (int i = 0; i < 8; i++) send(i, 16'h2000 + i);
    rd(0, 2'd1); idle(10, "R5 full count");
    for (int i = 0; i < 8; i++) send(i, 16'h3000 + i);
    idle(4, "R11 pending while full");
    send(5, 16'h5555); send(2, 16'h2222); idle(1, "R6 overflow event");
    idle(3, "R6 flags sticky");
    // full with pending: pop and push together
    rd(1, 2'd0); idle(1, "R10 swap");
    rd(0, 2'd1); idle(1, "R10 count stays 8");
    rd(1, 2'd0); idle(1, "R10 swap again");
    // clear with simultaneous set on channel 7 (pending, full)
    rd(0, 2'd1); wr(2'd2, 32'h2); send(7, 16'h7777); idle(1, "R7 clear with set");
    idle(1, "R7 set wins");
    wr(2'd2, 32'h2); idle(2, "R7 clear");
    rd(0, 2'd2); idle(1, "R7 clear bit reads 0");
    // drain everything
    for (int i = 0; i < 20; i++) begin rd(1, 2'd0); idle(1, "R11 drain"); end
    rd(0, 2'd1); idle(1, "R11 drained");

    // no-stall mode
    wr(2'd2, 32'h1); rd(0, 2'd2); idle(1, "R8 mode write");
    rd(0, 2'd2); idle(1, "R8 mode readback");
    rd(1, 2'd0); idle(3, "R9 empty read returns 0");
    rd(0, 2'd1); idle(1, "R9 count unchanged");

    // stall mode
    wr(2'd2, 32'h0); idle(1, "R8 mode off");
    rd(1, 2'd0); idle(3, "R8 stall on empty");
    send(0, 16'hBEEF); idle(1, "R8 still stalled");
    idle(1, "R8 stall released");
    idle(1, "R8 popped");
    rd(0, 2'd1); idle(2, "R8 final count");

    rst = 1'b1; rd(0, 2'd0); idle(2, "R1 second reset");
    rst = 1'b0; #1;
    rd(0, 2'd1); idle(1, "R1 state after second reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule